// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Unit

This block watches a bank of already-synchronised GPIO input levels and turns per-pin trigger conditions into sticky status bits. Each pin has two configuration inputs: a trigger-kind bit, where 0 means edge and 1 means level, and a polarity-invert bit. Together they select rising edge, falling edge, low level or high level. A status bit is captured whenever its pin's condition holds, whatever the state of that pin's enable.

Software sees the status and enable bitmaps as 32-bit words on a small register bus. A status word is cleared by writing ones. An enable word is a plain read/write mask. The single interrupt output is registered. It is the OR over all pins of status AND enable.

At start-up, software is expected to write zero to every enable word and all ones to every status word.

Top module: `gpirq_unit`

## Requirements
- R1: With trigger-kind 0 and invert 0, a pin whose level goes from 0 to 1 sets its status bit at the clock edge that first samples the 1. The bit then stays set until it is cleared.
- R2: With trigger-kind 0 and invert 1, only a 1-to-0 transition sets the status bit. A 0-to-1 transition leaves it clear.
- R3: With trigger-kind 1, the status bit is set on every cycle in which the pin is low (invert 0) or high (invert 1). A clear while the level still holds is undone on the next edge.
- R4: Writing to a status word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a trigger condition and a write-one-to-clear hit the same status bit at the same edge, the bit ends up set.
- R6: Status word k is at byte address 0x80 + 4k and enable word k is at 0x90 + 4k. Pin n is bit n mod 32 of word n/32. A read returns the register value on bus_rdata one cycle later, and bus_rdata holds until the next read. Unmapped addresses, and bits above the last pin, read as 0 and cannot be written.
- R7: Enable bits are written and read back through the bus. They do not affect status capture.
- R8: irq is asserted one cycle after some pin has both its status bit and its enable bit at 1, and deasserts one cycle after no such pin remains.
- R9: Reset clears status, enable, irq and bus_rdata. The first sample after reset never counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NUM_PINS | Synchronised pin levels |
| trig_lvl | input | NUM_PINS | Per-pin trigger kind: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin polarity invert |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Aggregated registered interrupt |

## Verification
Some rules are checked by the in-line properties on every cycle:
- a trigger beats a clear on the same bit;
- a written 1 clears a bit that is not being triggered;
- no status bit falls without a clear;
- enables are zero after reset;
- irq is never raised while the enables were all zero;
- no edge is reported from the first sample after reset.

Other behaviour can only be shown by the bench's scenarios. This covers the four trigger encodings, re-setting of level-triggered bits after a clear, the address map and zero padding, and the one-cycle irq latency. The bench covers these with directed sequences, then runs a random phase that is compared cycle by cycle with a reference model.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int WORD_W = 32;

  function automatic int words_for(input int pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] trig_inv,
  output logic [NUM_PINS-1:0] hit
);
  logic [NUM_PINS-1:0] prev_q;
  logic                primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_lvl;
      primed_q <= 1'b1;
    end
  end

  // polarity is folded in first, so one rule serves both edges and both levels
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic now_act, was_act;
    assign now_act = pin_lvl[i] ^ trig_inv[i];
    assign was_act = prev_q[i]  ^ trig_inv[i];
    assign hit[i]  = trig_lvl[i] ? ~now_act : (primed_q & now_act & ~was_act);
  end

  // R9: the first sample after reset yields no edge hit
  p_no_edge_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    !primed_q |-> ((hit & ~trig_lvl) == '0));
endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int                NUM_PINS  = 40,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] EN_BASE   = 8'h90
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] hit,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] status_o,
  output logic [NUM_PINS-1:0] enable_o
);
  localparam int NW   = words_for(NUM_PINS);
  localparam int NPAD = NW * WORD_W;

  logic [NUM_PINS-1:0] status_q, enable_q, clr, status_nx, enable_nx;
  logic [NPAD-1:0]     clr_pad, stat_pad, en_pad, en_pad_nx;
  logic [NW-1:0]       sel_stat, sel_en;
  logic [WORD_W-1:0]   rd_val;

  assign stat_pad = NPAD'(status_q);
  assign en_pad   = NPAD'(enable_q);

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign sel_stat[k] = (bus_addr == ADDR_W'(STAT_BASE + ADDR_W'(4 * k)));
    assign sel_en[k]   = (bus_addr == ADDR_W'(EN_BASE + ADDR_W'(4 * k)));
    assign clr_pad[k*WORD_W +: WORD_W] = (bus_wr && sel_stat[k]) ? bus_wdata : '0;
  end

  assign clr = clr_pad[NUM_PINS-1:0];

  always_comb begin
    en_pad_nx = en_pad;
    for (int k = 0; k < NW; k++) begin
      if (bus_wr && sel_en[k]) en_pad_nx[k*WORD_W +: WORD_W] = bus_wdata;
    end
  end

  assign enable_nx = en_pad_nx[NUM_PINS-1:0];
  // a trigger wins over a clear of the same bit
  assign status_nx = (status_q & ~clr) | hit;

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NW; k++) begin
      if (sel_stat[k]) rd_val = stat_pad[k*WORD_W +: WORD_W];
      if (sel_en[k])   rd_val = en_pad[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      enable_q  <= '0;
      bus_rdata <= '0;
    end else begin
      status_q <= status_nx;
      enable_q <= enable_nx;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(clr & ~hit)) == '0));

  // R1: a captured status bit only falls through a clear
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr)) == '0));

  p_en_reset_r9: assert property (@(posedge clk)
    rst |=> (enable_q == '0));
endmodule

// File: rtl/gpirq_unit.sv
module gpirq_unit #(
  parameter int                NUM_PINS  = 40,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] EN_BASE   = 8'h90
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq
);
  logic [NUM_PINS-1:0] hit, status, enable;

  gpirq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pin_lvl),
    .trig_lvl (trig_lvl),
    .trig_inv (trig_inv),
    .hit      (hit)
  );

  gpirq_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .STAT_BASE(STAT_BASE),
    .EN_BASE  (EN_BASE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .status_o (status),
    .enable_o (enable)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & enable);
  end

  // R7: the interrupt is never raised while every enable was off
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(enable) != '0));
endmodule

// File: tb/tb_gpirq_unit.sv
module tb_gpirq_unit;
  localparam int NP = 40;
  localparam int NW = (NP + 31) / 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_lvl = '0, trig_lvl = '0, trig_inv = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  gpirq_unit #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .trig_lvl(trig_lvl),
    .trig_inv(trig_inv), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  // reference model built from the requirements
  logic [NP-1:0] m_prev, m_stat, m_en, m_hit, m_clr;
  logic          m_primed, m_irq;
  logic [31:0]   m_rdata;
  logic [NW*32-1:0] m_sp, m_ep;

  function automatic logic [31:0] reg_view(input logic [7:0] a,
      input logic [NW*32-1:0] sp, input logic [NW*32-1:0] ep);
    logic [31:0] v = '0;
    for (int k = 0; k < NW; k++) begin
      if (a == 8'(8'h80 + 4 * k)) v = sp[k*32 +: 32];
      if (a == 8'(8'h90 + 4 * k)) v = ep[k*32 +: 32];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev = '0; m_stat = '0; m_en = '0; m_primed = 1'b0;
      m_irq = 1'b0; m_rdata = '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (trig_lvl[i]) m_hit[i] = (pin_lvl[i] == trig_inv[i]);
        else if (trig_inv[i]) m_hit[i] = m_primed && !pin_lvl[i] && m_prev[i];
        else m_hit[i] = m_primed && pin_lvl[i] && !m_prev[i];
      end
      m_sp = (NW*32)'(m_stat);
      m_ep = (NW*32)'(m_en);
      if (bus_rd) m_rdata = reg_view(bus_addr, m_sp, m_ep);
      m_irq = |(m_stat & m_en);
      m_sp = '0;
      for (int k = 0; k < NW; k++) begin
        if (bus_wr && bus_addr == 8'(8'h80 + 4 * k)) m_sp[k*32 +: 32] = bus_wdata;
        if (bus_wr && bus_addr == 8'(8'h90 + 4 * k)) m_ep[k*32 +: 32] = bus_wdata;
      end
      m_clr    = m_sp[NP-1:0];
      m_stat   = (m_stat & ~m_clr) | m_hit;
      m_en     = m_ep[NP-1:0];
      m_prev   = pin_lvl;
      m_primed = 1'b1;
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check32("R8 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check32("R6 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    pin_lvl[7] = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R9: reset state
    check32("R9 irq after reset", {31'd0, irq}, 32'd0);
    check32("R9 rdata after reset", bus_rdata, 32'd0);
    tick(); tick();
    do_read(8'h80, rd);
    check32("R9 no edge from first sample", rd, 32'd0);

    // R1 rising edge
    pin_lvl[3] = 1'b1;
    tick();
    do_read(8'h80, rd);
    check32("R1 rising edge capture", rd, 32'h8);

    // R4 write-one-to-clear
    do_write(8'h80, 32'h0);
    do_read(8'h80, rd);
    check32("R4 zero write keeps", rd, 32'h8);
    do_write(8'h80, 32'h8);
    do_read(8'h80, rd);
    check32("R4 one write clears", rd, 32'h0);

    // R2 falling edge on pin 35 (word 1, bit 3)
    trig_inv[35] = 1'b1;
    pin_lvl[35] = 1'b1;
    tick();
    do_read(8'h84, rd);
    check32("R2 rising ignored", rd, 32'h0);
    pin_lvl[35] = 1'b0;
    tick();
    do_read(8'h84, rd);
    check32("R2 falling edge capture", rd, 32'h8);
    do_write(8'h84, 32'h8);

    // R3 level triggers on pin 10
    trig_lvl[10] = 1'b1;
    tick();
    do_read(8'h80, rd);
    check32("R3 low level capture", rd, 32'h400);
    do_write(8'h80, 32'h400);
    do_read(8'h80, rd);
    check32("R3 held level re-sets", rd, 32'h400);
    pin_lvl[10] = 1'b1;
    do_write(8'h80, 32'h400);
    do_read(8'h80, rd);
    check32("R3 released level stays clear", rd, 32'h0);
    trig_inv[10] = 1'b1;
    tick();
    do_read(8'h80, rd);
    check32("R3 high level capture", rd, 32'h400);

    // R7 / R8 enable gating and irq latency
    check32("R7 status without enable gives no irq", {31'd0, irq}, 32'd0);
    do_write(8'h90, 32'h400);
    tick();
    check32("R8 irq one cycle after enable", {31'd0, irq}, 32'd1);
    do_read(8'h90, rd);
    check32("R7 enable readback", rd, 32'h400);
    trig_lvl[10] = 1'b0;
    do_write(8'h80, 32'h400);
    tick();
    check32("R8 irq drops after clear", {31'd0, irq}, 32'd0);
    do_write(8'h90, 32'h0);

    // R5 set wins over clear in the same cycle
    pin_lvl[5] = 1'b1;
    do_write(8'h80, 32'h20);
    do_read(8'h80, rd);
    check32("R5 set beats clear", rd, 32'h20);
    do_write(8'h80, 32'h20);
    do_read(8'h80, rd);
    check32("R5 later clear works", rd, 32'h0);

    // R6 map edges and padding
    do_write(8'h94, 32'hFFFF_FFFF);
    do_read(8'h94, rd);
    check32("R6 unused enable bits read zero", rd, 32'h0000_00FF);
    do_read(8'h88, rd);
    check32("R6 unmapped status slot", rd, 32'h0);
    do_read(8'h98, rd);
    check32("R6 unmapped enable slot", rd, 32'h0);
    do_write(8'h94, 32'h0);

    // random phase, compared with the model every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] addr_pick;
      if ($urandom_range(3) == 0)
        pin_lvl = pin_lvl ^ NP'({$urandom(), $urandom()} & {$urandom(), $urandom()});
      if ($urandom_range(31) == 0) begin
        trig_lvl = NP'({$urandom(), $urandom()} & {$urandom(), $urandom()});
        trig_inv = NP'({$urandom(), $urandom()});
      end
      case ($urandom_range(6))
        0: addr_pick = 8'h80;
        1: addr_pick = 8'h84;
        2: addr_pick = 8'h90;
        3: addr_pick = 8'h94;
        4: addr_pick = 8'h88;
        5: addr_pick = 8'h98;
        default: addr_pick = 8'($urandom());
      endcase
      bus_addr  = addr_pick;
      bus_rd    = ($urandom_range(1) == 1);
      bus_wr    = ($urandom_range(3) == 0);
      bus_wdata = $urandom();
      tick();
    end
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule